// File: doc/BRIEF.md
# Grouped-Direction GPIO Port with Key Wake-Up

This block is an eight-pin bidirectional port that sits on a microcontroller's register bus. Each pin has an output latch, a tri-state driver enable and a path that returns the pin level to the bus. Software chooses the direction for all pins at once. A single flag asks the pad ring for pull-ups on every pin, and it counts only while the port is an input. An external bus controller can take over the pins to carry a multiplexed address/data bus. The controller supplies its drive value and enable as plain inputs.

Every pin passes through a two-flop synchronizer. A falling-edge detector watches all the synchronized pins and sets a sticky key interrupt flag. When the key mask is open, the flag also raises a wake-up line that the power controller uses to leave standby.

Register map. A write takes effect at the clock edge on which `reg_wr` is high. Reads are combinational from `reg_addr`.

| Address | Bits | Contents |
|---|---|---|
| 0 | all | Output latch |
| 1 | bit0 | Output mode |
| 1 | bit1 | External bus mode |
| 1 | bit2 | Pull-up request |
| 2 | bit0 | Key flag |
| 2 | bit1 | Key mask (1 = masked) |

Top module: `gpio8_keywake`

## Requirements
- R1: After reset the pins are inputs (`pin_oe` all zero). The latch and the control register read 0, `pullup_en` is 0, `key_flag` and `wake` are 0, and address 2 reads 2'b10 (mask set).
- R2: With control bit0 = 1 and bit1 = 0, `pin_out` equals the latch, `pin_oe` is all ones, and address 0 reads back the latch whatever the pin levels are.
- R3: With control bit0 = 0, `pin_oe` is all zeros. Address 0 returns the pin levels. A pin change driven before a clock edge is visible after the second edge.
- R4: `pullup_en` is 1 only when control bit2 = 1 and bits 0 and 1 are both 0.
- R5: A 1-to-0 transition on any single pin sets `key_flag`. It is visible after the third clock edge from the change, not earlier.
- R6: Rising transitions and steady levels never set `key_flag`.
- R7: `wake` is high exactly when `key_flag` is 1 and the key mask (address 2 bit1) is 0.
- R8: A write of 0 to address 2 bit0 clears `key_flag`. A write of 1 to that bit leaves the flag unchanged.
- R9: If a falling edge sets the flag in the same cycle that a clear write happens, the flag ends up set.
- R10: With control bit1 = 1, `pin_out` equals `xbus_out` and every bit of `pin_oe` equals `xbus_oe`, whatever bit0 says. The latch is kept and is driven again once the bus mode is left in output mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Read data |
| pin_in | input | W | Pin levels from the pads |
| pin_out | output | W | Pin drive values |
| pin_oe | output | W | Pin drive enables |
| pullup_en | output | 1 | Pull-up request to the pads |
| xbus_out | input | W | External bus drive value |
| xbus_oe | input | 1 | External bus drive enable |
| key_flag | output | 1 | Key interrupt flag |
| wake | output | 1 | Standby release |

## Verification
The checker makes two assumptions. It takes the register strobe and address as clean, synchronous signals. It also assumes a flag can only be raised by an edge the detector saw in the previous cycle. The bench therefore changes every input half a period away from the rising edge, so each change falls cleanly into a known edge. It also holds the pins steady whenever it needs to show that the flag stays quiet. Pin values in output and bus modes are set to differ from the driven value, so a leaking read path would show up.

// File: rtl/gpio8_keywake.sv
module gpio8_keywake #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   reg_addr,
  input  logic         reg_wr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic         pullup_en,
  input  logic [W-1:0] xbus_out,
  input  logic         xbus_oe,
  output logic         key_flag,
  output logic         wake
);

  localparam logic [1:0] A_LATCH = 2'd0;
  localparam logic [1:0] A_CTRL  = 2'd1;
  localparam logic [1:0] A_KEY   = 2'd2;

  logic [W-1:0] latch_q;
  logic [W-1:0] meta_q, sync_q, prev_q;
  logic         out_mode, ext_mode, pu_req;
  logic         mask_q;
  logic         fall_any;

  wire wr_latch = reg_wr && reg_addr == A_LATCH;
  wire wr_ctrl  = reg_wr && reg_addr == A_CTRL;
  wire wr_key   = reg_wr && reg_addr == A_KEY;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= pin_in;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign fall_any = |(prev_q & ~sync_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else if (wr_latch) latch_q <= reg_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_mode <= 1'b0;
      ext_mode <= 1'b0;
      pu_req   <= 1'b0;
    end else if (wr_ctrl) begin
      out_mode <= reg_wdata[0];
      ext_mode <= reg_wdata[1];
      pu_req   <= reg_wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_flag <= 1'b0;
      mask_q   <= 1'b1;
    end else begin
      if (fall_any)                     key_flag <= 1'b1;
      else if (wr_key && !reg_wdata[0]) key_flag <= 1'b0;
      if (wr_key) mask_q <= reg_wdata[1];
    end
  end

  assign wake      = key_flag & ~mask_q;
  assign pullup_en = pu_req & ~out_mode & ~ext_mode;
  assign pin_out   = ext_mode ? xbus_out : latch_q;
  assign pin_oe    = ext_mode ? {W{xbus_oe}} : {W{out_mode}};

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_LATCH: reg_rdata = (out_mode && !ext_mode) ? latch_q : sync_q;
      A_CTRL:  reg_rdata[2:0] = {pu_req, ext_mode, out_mode};
      A_KEY:   reg_rdata[1:0] = {mask_q, key_flag};
      default: reg_rdata = '0;
    endcase
  end

endmodule

module gpio8_keywake_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   reg_addr,
  input logic         reg_wr,
  input logic [W-1:0] reg_wdata,
  input logic [W-1:0] pin_oe,
  input logic         pullup_en,
  input logic         key_flag,
  input logic         wake,
  input logic         fall_any
);

  AST_OE_GROUP: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe == '0) || (pin_oe == '1)); // R2

  AST_PU_INPUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe != '0) |-> !pullup_en); // R4

  AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    fall_any |=> key_flag); // R5

  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(key_flag) |-> $past(fall_any)); // R6

  AST_WAKE_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !key_flag |-> !wake); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (key_flag && !(reg_wr && reg_addr == 2'd2 && !reg_wdata[0])) |=> key_flag); // R8

endmodule

bind gpio8_keywake gpio8_keywake_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .pin_oe(pin_oe), .pullup_en(pullup_en),
  .key_flag(key_flag), .wake(wake), .fall_any(fall_any)
);

// File: tb/test_gpio8_keywake.sv
`timescale 1ns/1ps
module test_gpio8_keywake;
  localparam int W = 8;
  logic clk = 0, rst_n = 0;
  logic [1:0] reg_addr = 0;
  logic reg_wr = 0;
  logic [W-1:0] reg_wdata = 0, reg_rdata, pin_in = 8'hFF, pin_out, pin_oe, xbus_out = 0;
  logic xbus_oe = 0, pullup_en, key_flag, wake;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio8_keywake #(.W(W)) i_gpio8_keywake (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pullup_en(pullup_en),
    .xbus_out(xbus_out), .xbus_oe(xbus_oe), .key_flag(key_flag), .wake(wake));

  // {out_mode, value, expected read, expected oe}
  localparam logic [24:0] VEC [8] = '{
    {1'b0, 8'hA5, 8'hA5, 8'h00}, {1'b0, 8'h3C, 8'h3C, 8'h00},
    {1'b0, 8'hFF, 8'hFF, 8'h00}, {1'b1, 8'h5A, 8'h5A, 8'hFF},
    {1'b1, 8'h00, 8'h00, 8'hFF}, {1'b1, 8'hC3, 8'hC3, 8'hFF},
    {1'b0, 8'h00, 8'h00, 8'h00}, {1'b0, 8'h81, 8'h81, 8'h00}};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #0.5; d = reg_rdata;
  endtask

  task automatic waitn(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    waitn(2); rst_n = 1; waitn(3);
    check("R1 oe", pin_oe, 0); check("R1 pullup", pullup_en, 0);
    check("R1 flag", key_flag, 0); check("R1 wake", wake, 0);
    rd(2, d); check("R1 key reg", d, 8'h02);
    rd(1, d); check("R1 ctrl reg", d, 8'h00);

    foreach (VEC[i]) begin
      wr(1, {7'b0, VEC[i][24]});
      if (VEC[i][24]) begin wr(0, VEC[i][23:16]); pin_in = ~VEC[i][23:16]; end
      else pin_in = VEC[i][23:16];
      waitn(3);
      rd(0, d);
      check(VEC[i][24] ? "R2 read" : "R3 read", d, VEC[i][15:8]);
      check(VEC[i][24] ? "R2 oe" : "R3 oe", pin_oe, VEC[i][7:0]);
      if (VEC[i][24]) check("R2 drive", pin_out, VEC[i][23:16]);
    end

    // R3 latency: visible after second edge, not first
    wr(1, 0); pin_in = 8'h00; waitn(4);
    pin_in = 8'h5F; waitn(1); rd(0, d); check("R3 after one edge", d, 8'h00);
    waitn(1); rd(0, d); check("R3 after two edges", d, 8'h5F);

    // R8 clear and write-1 ignored
    pin_in = 8'h00; waitn(4);
    wr(2, 8'h02); check("R8 clear", key_flag, 0);
    wr(2, 8'h03); check("R8 write one ignored", key_flag, 0);
    // R6 rising edge
    pin_in = 8'hFF; waitn(5); check("R6 rise no flag", key_flag, 0);
    waitn(5); check("R6 steady no flag", key_flag, 0);

    // R5 single pin fall, latency
    pin_in = 8'hF7; waitn(2); check("R5 not before third edge", key_flag, 0);
    waitn(1); check("R5 set", key_flag, 1);
    check("R7 masked no wake", wake, 0);
    wr(2, 8'h01); check("R7 unmasked wake", wake, 1);
    wr(2, 8'h01); check("R8 write one keeps flag", key_flag, 1);
    wr(2, 8'h00); check("R8 cleared", key_flag, 0);
    check("R7 wake drops", wake, 0);

    // R9 set wins over clear
    pin_in = 8'hF6; waitn(2);
    wr(2, 8'h00); check("R9 set wins", key_flag, 1);
    check("R7 wake on collision", wake, 1);
    wr(2, 8'h02);

    // R4 pull-up gating
    wr(1, 8'h04); check("R4 input", pullup_en, 1);
    wr(1, 8'h05); check("R4 output", pullup_en, 0);
    wr(1, 8'h06); check("R4 ext", pullup_en, 0);

    // R10 external bus
    wr(1, 8'h01); wr(0, 8'h3E);
    xbus_out = 8'h9C; xbus_oe = 1;
    wr(1, 8'h03); #0.5;
    check("R10 drive", pin_out, 8'h9C); check("R10 oe", pin_oe, 8'hFF);
    xbus_oe = 0; #0.5; check("R10 oe off", pin_oe, 8'h00);
    wr(1, 8'h01); #0.5;
    check("R10 latch kept", pin_out, 8'h3E); check("R10 oe back", pin_oe, 8'hFF);

    // R1 reset again
    rst_n = 0; #0.5;
    check("R1 async oe", pin_oe, 0); check("R1 async flag", key_flag, 0);
    rd(0, d); check("R1 latch", pin_out, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule